// File: doc/BRIEF.md
# Two-Pin Interrupt Routing Controller

The block gathers event lines from seven on-chip detection functions (data-ready, freefall/motion, tap, orientation, transient, FIFO and auto-sleep) and turns each rising edge into a sticky pending bit. A pending bit stays set until the owning function signals that its own source register has been read. To do that, the function pulses a per-source clear strobe into this block. Reading the collected status word through the register port leaves the pending bits unchanged.

Each source has an enable bit and a route bit. The route bit sends the source to one of two interrupt pins. Each pin is the OR of the enabled pending bits routed to it. One shared control field sets the asserted level of both pins and chooses between push-pull and open-drain drive. In open-drain mode an idle pin is released through its output-enable signal.

Software reaches the block through a small synchronous register port with four 8-bit registers. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `irq_router`

## Requirements
- R1: A pending bit is set on the clock edge at which its event line is high and was low at the previous edge. A line held high sets the bit only once, so after a clear the bit stays low until the line falls and rises again.
- R2: Pulsing a source's clear strobe clears that pending bit at the next edge. Reading the status register (address 0) clears nothing.
- R3: If a clear strobe and a new rising edge of the same source occur at the same edge, the pending bit stays set.
- R4: A pending bit is set whether or not its enable bit is set. It drives a pin only while its enable bit (address 1, bit i for source i) is 1.
- R5: A route bit (address 2, bit i) of 1 sends source i to pin 1, and a route bit of 0 sends it to pin 2.
- R6: Each pin is asserted exactly when at least one enabled pending bit is routed to it.
- R7: Control bit 0 at address 3 sets the asserted level of both pins: 1 means active high, 0 means active low. A deasserted pin drives the opposite level.
- R8: Control bit 1 at address 3 selects the drive type. When it is 0 (push-pull), both output enables are always 1. When it is 1 (open-drain), a pin's output enable equals its asserted state.
- R9: The register map is as follows. Address 0 returns the pending bits and ignores writes. Addresses 1, 2 and 3 read back what was last written, limited to their defined bits. Source order in every field is bit 0 data-ready, bit 1 freefall/motion, bit 2 tap, bit 3 orientation, bit 4 transient, bit 5 FIFO and bit 6 auto-sleep. Undefined bits read 0.
- R10: After reset all pending, enable, route and control bits are 0. Both pins are therefore push-pull, active low, deasserted (driving 1) and routed to pin 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event lines from the detection functions |
| clr_i | input | 7 | Per-source clear strobes (source register read) |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| int1_o | output | 1 | Pin 1 output level |
| int1_oe_o | output | 1 | Pin 1 output enable |
| int2_o | output | 1 | Pin 2 output level |
| int2_oe_o | output | 1 | Pin 2 output enable |

## Verification
The assertions check on every cycle that a rising edge always leaves its bit set, including when a clear arrives at the same edge. They also check that a clear without a new edge empties the bit, that untouched bits hold, and that push-pull keeps both enables high. Two further properties hold on every cycle: open-drain enables a pin only at its asserted level, and nothing reaches a pin while no enabled bit is pending. Other behaviours need a reference model and specific stimulus, so only the bench's scenarios can show them. These are the per-pin route selection, the exact OR across several routed sources, the register readback, ignored writes to the status address, and the level-held event that must not set its bit again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 7;
  localparam int REG_DW  = 8;
  localparam int REG_AW  = 2;

  typedef enum logic [REG_AW-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_ENABLE = 2'd1,
    ADDR_ROUTE  = 2'd2,
    ADDR_PINCTL = 2'd3
  } reg_addr_e;

  // source bit order
  localparam int SRC_DRDY  = 0;
  localparam int SRC_FFMT  = 1;
  localparam int SRC_TAP   = 2;
  localparam int SRC_ORIENT= 3;
  localparam int SRC_TRANS = 4;
  localparam int SRC_FIFO  = 5;
  localparam int SRC_SLEEP = 6;

  typedef struct packed {
    logic od;   // 1: open-drain
    logic pol;  // 1: active high
  } pin_cfg_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N = irq_pkg::NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] evt_q;
  logic [N-1:0] status_q;
  logic [N-1:0] rise;

  assign rise = evt_i & ~evt_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        evt_q[i]    <= 1'b0;
        status_q[i] <= 1'b0;
      end else begin
        evt_q[i] <= evt_i[i];
        // a new edge wins over a clear
        if (rise[i])       status_q[i] <= 1'b1;
        else if (clr_i[i]) status_q[i] <= 1'b0;
      end
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N  = irq_pkg::NUM_SRC,
  parameter int DW = irq_pkg::REG_DW,
  parameter int AW = irq_pkg::REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      route_o,
  output irq_pkg::pin_cfg_t pcfg_o,
  output logic [DW-1:0]     rdata_o
);
  import irq_pkg::*;

  logic [N-1:0] en_q, route_q;
  pin_cfg_t     pcfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
      pcfg_q  <= '0;
    end else if (we_i) begin
      unique case (reg_addr_e'(addr_i))
        ADDR_ENABLE: en_q    <= wdata_i[N-1:0];
        ADDR_ROUTE:  route_q <= wdata_i[N-1:0];
        ADDR_PINCTL: pcfg_q  <= '{od: wdata_i[1], pol: wdata_i[0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      ADDR_STATUS: rdata_o[N-1:0] = status_i;
      ADDR_ENABLE: rdata_o[N-1:0] = en_q;
      ADDR_ROUTE:  rdata_o[N-1:0] = route_q;
      ADDR_PINCTL: rdata_o[1:0]   = {pcfg_q.od, pcfg_q.pol};
      default: ;
    endcase
  end

  if (N < DW) begin : g_spare
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DW-1:N];
  end

  assign en_o    = en_q;
  assign route_o = route_q;
  assign pcfg_o  = pcfg_q;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int N = irq_pkg::NUM_SRC
) (
  input  logic [N-1:0]      status_i,
  input  logic [N-1:0]      sel_i,
  input  irq_pkg::pin_cfg_t pcfg_i,
  output logic              pin_o,
  output logic              oe_o
);
  logic active;

  assign active = |(status_i & sel_i);
  assign pin_o  = active ? pcfg_i.pol : ~pcfg_i.pol;
  assign oe_o   = pcfg_i.od ? active : 1'b1;
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N  = irq_pkg::NUM_SRC,
  parameter int DW = irq_pkg::REG_DW,
  parameter int AW = irq_pkg::REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  evt_i,
  input  logic [N-1:0]  clr_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          int1_o,
  output logic          int1_oe_o,
  output logic          int2_o,
  output logic          int2_oe_o
);
  import irq_pkg::*;

  localparam int NPIN = 2;

  logic [N-1:0] status_q, en_q, route_q;
  pin_cfg_t     pcfg_q;
  logic         pol_q, od_q;
  logic [NPIN-1:0] pin_lvl, pin_oe;

  irq_status_bank #(.N(N)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .clr_i    (clr_i),
    .status_o (status_q)
  );

  irq_cfg_regs #(.N(N), .DW(DW), .AW(AW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_q),
    .en_o     (en_q),
    .route_o  (route_q),
    .pcfg_o   (pcfg_q),
    .rdata_o  (reg_rdata_o)
  );

  assign pol_q = pcfg_q.pol;
  assign od_q  = pcfg_q.od;

  // index 0 -> pin 1 (route=1), index 1 -> pin 2 (route=0)
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [N-1:0] sel;
    assign sel = en_q & ((p == 0) ? route_q : ~route_q);
    irq_pin_drv #(.N(N)) u_drv (
      .status_i (status_q),
      .sel_i    (sel),
      .pcfg_i   (pcfg_q),
      .pin_o    (pin_lvl[p]),
      .oe_o     (pin_oe[p])
    );
  end

  assign int1_o    = pin_lvl[0];
  assign int1_oe_o = pin_oe[0];
  assign int2_o    = pin_lvl[1];
  assign int2_oe_o = pin_oe[1];
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N = irq_pkg::NUM_SRC
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] evt_i,
  input logic [N-1:0] clr_i,
  input logic [N-1:0] status_i,
  input logic [N-1:0] en_i,
  input logic         pol_i,
  input logic         od_i,
  input logic         int1_o,
  input logic         int1_oe_o,
  input logic         int2_o,
  input logic         int2_oe_o
);
  logic [N-1:0] evt_d;
  logic [N-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_d <= '0;
    else         evt_d <= evt_i;
  end
  assign rise = evt_i & ~evt_d;

  // R1 and R3: an edge always leaves its bit set
  assert_edge_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((status_i & $past(rise)) == $past(rise)));

  assert_clear_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~rise)) |=> ((status_i & $past(clr_i & ~rise)) == '0));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_i & ~clr_i)) |=> ((status_i & $past(status_i & ~clr_i)) == $past(status_i & ~clr_i)));

  assert_idle_pins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i & en_i) == '0) |-> (int1_o == ~pol_i && int2_o == ~pol_i));

  assert_pushpull_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !od_i |-> (int1_oe_o && int2_oe_o));

  assert_od_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od_i |-> ((int1_oe_o == (int1_o == pol_i)) && (int2_oe_o == (int2_o == pol_i))));
endmodule

bind irq_router irq_router_chk #(.N(N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .clr_i     (clr_i),
  .status_i  (status_q),
  .en_i      (en_q),
  .pol_i     (pol_q),
  .od_i      (od_q),
  .int1_o    (int1_o),
  .int1_oe_o (int1_oe_o),
  .int2_o    (int2_o),
  .int2_oe_o (int2_oe_o)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
  localparam int N = 7;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] evt_i = '0;
  logic [6:0] clr_i = '0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       int1_o, int1_oe_o, int2_o, int2_oe_o;

  int vectors = 0;
  int errors  = 0;
  string tag = "R10";
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_router u_irq_router (
    .clk_i, .rst_ni, .evt_i, .clr_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .int1_o, .int1_oe_o, .int2_o, .int2_oe_o
  );

  // behavioural reference
  bit [6:0] m_pend, m_en, m_rt, m_prev;
  bit       m_pol, m_od;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend = '0; m_en = '0; m_rt = '0; m_prev = '0; m_pol = 0; m_od = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (evt_i[i] && !m_prev[i]) m_pend[i] = 1;
        else if (clr_i[i])          m_pend[i] = 0;
      end
      m_prev = evt_i;
      if (reg_we_i) begin
        if (reg_addr_i == 2'd1) m_en = reg_wdata_i[6:0];
        if (reg_addr_i == 2'd2) m_rt = reg_wdata_i[6:0];
        if (reg_addr_i == 2'd3) begin m_pol = reg_wdata_i[0]; m_od = reg_wdata_i[1]; end
      end
    end
  end

  task automatic chk1(string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit a1, a2;
    bit [7:0] er;
    a1 = |(m_pend & m_en & m_rt);
    a2 = |(m_pend & m_en & ~m_rt);
    case (reg_addr_i)
      2'd0: er = {1'b0, m_pend};
      2'd1: er = {1'b0, m_en};
      2'd2: er = {1'b0, m_rt};
      default: er = {6'b0, m_od, m_pol};
    endcase
    chk1("rdata", reg_rdata_o, er);
    chk1("int1", {7'b0, int1_o}, {7'b0, a1 ? m_pol : ~m_pol});
    chk1("int1_oe", {7'b0, int1_oe_o}, {7'b0, m_od ? a1 : 1'b1});
    chk1("int2", {7'b0, int2_o}, {7'b0, a2 ? m_pol : ~m_pol});
    chk1("int2_oe", {7'b0, int2_oe_o}, {7'b0, m_od ? a2 : 1'b1});
  endtask

  // one cycle: check settled outputs, then apply new inputs
  task automatic cyc(bit [6:0] e, bit [6:0] c, bit we, bit [1:0] a, bit [7:0] d);
    @(negedge clk_i);
    compare();
    evt_i = e; clr_i = c; reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
  endtask

  task automatic wr(bit [1:0] a, bit [7:0] d);
    cyc(evt_i, '0, 1, a, d);
  endtask

  task automatic rd(bit [1:0] a);
    cyc(evt_i, '0, 0, a, 8'h00);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state on all registers and pins
    tag = "R10";
    for (int a = 0; a < 4; a++) begin
      @(negedge clk_i); compare(); reg_addr_i = 2'(a);
    end
    rst_ni = 1'b1;
    rd(0); rd(1); rd(2); rd(3);

    // R9: readback, status address ignores writes, spare bits read zero
    tag = "R9";
    wr(1, 8'hFF); wr(2, 8'hAA); wr(3, 8'hFC); wr(0, 8'hFF);
    rd(0); rd(1); rd(2); rd(3);
    wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00); rd(1);

    // R4: pending sets while disabled, pins stay idle
    tag = "R4";
    cyc(7'h09, 0, 0, 0, 0); cyc(7'h00, 0, 0, 0, 0); rd(0);
    wr(1, 8'h01); rd(0); rd(0);

    // R1: held level does not re-set after clear
    tag = "R1";
    cyc(7'h10, 0, 0, 0, 0); cyc(7'h10, 0, 0, 0, 0);
    cyc(7'h10, 7'h10, 0, 0, 0); cyc(7'h10, 0, 0, 0, 0); rd(0); rd(0);
    cyc(7'h00, 0, 0, 0, 0); cyc(7'h10, 0, 0, 0, 0); rd(0);

    // R2: status read clears nothing, strobe clears its bit only
    tag = "R2";
    rd(0); rd(0);
    cyc(7'h00, 7'h01, 0, 0, 0); rd(0);
    cyc(7'h00, 7'h18, 0, 0, 0); rd(0);

    // R3: clear together with a new edge keeps the bit
    tag = "R3";
    cyc(7'h20, 7'h20, 0, 0, 0); rd(0); cyc(7'h00, 0, 0, 0, 0); rd(0);
    cyc(7'h00, 7'h20, 0, 0, 0); rd(0);

    // R5: route each source to either pin
    tag = "R5";
    wr(1, 8'h7F); wr(2, 8'h00);
    cyc(7'h04, 0, 0, 0, 0); rd(0); wr(2, 8'h04); rd(2);
    cyc(7'h00, 7'h04, 0, 0, 0); rd(0);

    // R6: OR across several routed sources
    tag = "R6";
    wr(2, 8'h0F);
    cyc(7'h41, 0, 0, 0, 0); rd(0);
    cyc(7'h00, 7'h01, 0, 0, 0); rd(0);
    cyc(7'h00, 7'h40, 0, 0, 0); rd(0);

    // R7: active-high polarity
    tag = "R7";
    wr(3, 8'h01); rd(3);
    cyc(7'h02, 0, 0, 0, 0); rd(0); cyc(7'h00, 7'h02, 0, 0, 0); rd(0);

    // R8: open-drain enables follow asserted state
    tag = "R8";
    wr(3, 8'h02); rd(3);
    cyc(7'h08, 0, 0, 0, 0); rd(0); wr(3, 8'h03); rd(0);
    cyc(7'h00, 7'h7F, 0, 0, 0); rd(0);

    // R6: mixed random traffic against the model
    tag = "R6";
    for (int k = 0; k < 400; k++) begin
      bit [31:0] r;
      r = $urandom;
      cyc(r[6:0], r[13:7] & r[20:14], (r[23:21] == 0), r[25:24], r[31:24]);
    end
    rd(0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule